// File: doc/BRIEF.md
# Atomic Swap Sequencer

This block swaps one register value with one memory location as a single indivisible operation. A requester hands it a base address, a store value and a size flag that selects a word or a byte swap. The sequencer reads the location, then writes the store value to the same address. It holds a bus lock output from the start of the read until the write has been acknowledged, so no other master can reach that location between the two accesses.

When the swap finishes, the block returns the old memory contents, already aligned for writeback into a register. It also reports a cycle total: the data cycles spent on the read, plus the data cycles spent on the write, plus one internal cycle. Each access uses a simple request/acknowledge handshake. The request stays high until the slave acknowledges it, and the slave may insert any number of wait states.

The memory bus is word wide and little-endian. The byte at address A sits in lane A[1:0], which is bits 8*A[1:0]+7 down to 8*A[1:0] of the data word.

Top module: `swap_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy`, `done`, `mem_req` and `mem_lock` are 0.
- R2: A `start` sampled high while idle latches address, data and size. The read request (`mem_req`=1, `mem_we`=0, `mem_addr` equal to the latched address, `mem_byte` equal to the size flag) becomes visible two clock edges after the `start` edge.
- R3: The write to the same address is issued only after the read has been acknowledged. Exactly one cycle with `mem_req` low separates the two accesses.
- R4: `mem_lock` is high from the cycle the read request rises through the cycle the write is acknowledged, including the gap cycle between the accesses. It is low in the following cycle.
- R5: For a word swap, `old_data` equals the read word rotated right by 8 × address[1:0].
- R6: For a byte swap, `old_data` equals the byte from lane address[1:0], zero-extended to the full width.
- R7: A byte swap writes the low 8 bits of the store value replicated into every lane, with `mem_byte`=1, so the upper store bits never reach the bus. A word swap writes the full store value.
- R8: `cyc_total` = read cycles + write cycles + 1. An access's cycle count is the number of cycles its `mem_req` is high, including the acknowledge cycle.
- R9: `done` is a single-cycle pulse in the cycle after the write acknowledge. `busy` is low in the cycle after `done`. `old_data` and `cyc_total` are valid while `done` is high.
- R10: A `start` raised while `busy` is high is ignored. No extra access is issued and the running swap keeps its original address.
- R11: While `mem_req` is high and not yet acknowledged, `mem_req` stays high and `mem_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a swap (sampled while idle) |
| st_addr | input | AW | Base address of the swap |
| st_data | input | DW | Value to store |
| st_byte | input | 1 | 1 = byte swap, 0 = word swap |
| busy | output | 1 | A swap is in progress |
| done | output | 1 | One-cycle completion pulse |
| old_data | output | DW | Aligned previous memory contents |
| cyc_total | output | CW | Read cycles + write cycles + 1 |
| mem_req | output | 1 | Bus access request, held until acknowledge |
| mem_we | output | 1 | 1 = write access |
| mem_byte | output | 1 | Access size, 1 = byte |
| mem_lock | output | 1 | Bus lock held across the swap |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Slave acknowledge, one cycle |
| mem_rdata | input | DW | Read data, valid with acknowledge |

## Verification
The bench sweeps both sizes, all four address offsets and every pairing of zero to three wait states on the read and on the write.

- A rotation built with the wrong direction or the wrong shift amount returns the wrong bytes at nonzero offsets.
- A byte path that takes lane 0 instead of the addressed lane, or that forgets zero extension, fails the byte cases at offsets 1 to 3.
- Dropping the lock during the gap between accesses is caught by the bus monitor.
- Issuing the write early, or back to back with the read, is also caught by the bus monitor.
- A miscounted cycle total shows up as soon as the read and write wait states differ.
- A `start` pulse injected mid-swap exposes a sequencer that restarts or re-latches its address.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_WRITE,
    ST_WAIT_WR,
    ST_DONE
  } swap_state_e;
endpackage

// File: rtl/swap_align.sv
// Rotates the returned word so the addressed lane lands at bit 0,
// then optionally zero-extends a single byte.
module swap_align #(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0] word_in,
  input  logic [LW-1:0] lane_sel,
  input  logic          is_byte,
  output logic [DW-1:0] word_out
);
  logic [2*DW-1:0] doubled;
  logic [DW-1:0]   rot [LANES];

  assign doubled = {word_in, word_in};

  for (genvar s = 0; s < LANES; s++) begin : g_rot
    assign rot[s] = doubled[8*s +: DW];
  end

  always_comb begin
    if (is_byte) word_out = {{(DW-8){1'b0}}, rot[lane_sel][7:0]};
    else         word_out = rot[lane_sel];
  end
endmodule

// File: rtl/swap_wdata.sv
// Builds the write word: full value for word swaps, low byte in every lane otherwise.
module swap_wdata #(
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic [DW-1:0] value,
  input  logic          is_byte,
  output logic [DW-1:0] bus_word
);
  logic [DW-1:0] repl;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign repl[8*l +: 8] = value[7:0];
  end

  assign bus_word = is_byte ? repl : value;
endmodule

// File: rtl/swap_cnt.sv
// Per-access cycle counter: loads 1 on issue, counts each further waiting cycle.
module swap_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (load)                 count <= ONE;
    else if (inc && (count != '1)) count <= count + ONE;
  end
endmodule

// File: rtl/swap_fsm.sv
module swap_fsm
  import swap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_byte,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] old_data,
  output logic [CW-1:0] cyc_total,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] aligned_rd,
  input  logic [DW-1:0] wr_word,
  input  logic [CW-1:0] acc_cnt,
  output logic          cnt_load,
  output logic          cnt_inc,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_byte
);
  localparam logic [CW-1:0] ONE = CW'(1);

  swap_state_e   state;
  logic [CW-1:0] rd_cyc;

  assign busy     = (state != ST_IDLE);
  assign cnt_load = (state == ST_READ) || (state == ST_WRITE);
  assign cnt_inc  = ((state == ST_WAIT_RD) || (state == ST_WAIT_WR)) && !mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      old_data  <= '0;
      cyc_total <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_byte  <= 1'b0;
      mem_lock  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_cyc    <= '0;
      op_addr   <= '0;
      op_data   <= '0;
      op_byte   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_addr <= st_addr;
            op_data <= st_data;
            op_byte <= st_byte;
            state   <= ST_READ;
          end
        end
        ST_READ: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_lock <= 1'b1;
          mem_addr <= op_addr;
          mem_byte <= op_byte;
          state    <= ST_WAIT_RD;
        end
        ST_WAIT_RD: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            old_data <= aligned_rd;
            rd_cyc   <= acc_cnt;
            state    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_wdata <= wr_word;
          state     <= ST_WAIT_WR;
        end
        ST_WAIT_WR: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_lock  <= 1'b0;
            cyc_total <= rd_cyc + acc_cnt + ONE;
            done      <= 1'b1;
            state     <= ST_DONE;
          end
        end
        ST_DONE: begin
          done  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swap_seq.sv
module swap_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_byte,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] old_data,
  output logic [CW-1:0] cyc_total,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int LANES = DW / 8;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DW-1:0] aligned_rd;
  logic [DW-1:0] wr_word;
  logic [CW-1:0] acc_cnt;
  logic          cnt_load;
  logic          cnt_inc;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          op_byte;

  swap_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .st_addr(st_addr), .st_data(st_data),
    .st_byte(st_byte), .busy(busy), .done(done), .old_data(old_data),
    .cyc_total(cyc_total), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .aligned_rd(aligned_rd),
    .wr_word(wr_word), .acc_cnt(acc_cnt), .cnt_load(cnt_load),
    .cnt_inc(cnt_inc), .op_addr(op_addr), .op_data(op_data), .op_byte(op_byte)
  );

  swap_align #(.DW(DW)) u_align (
    .word_in(mem_rdata), .lane_sel(op_addr[LW-1:0]), .is_byte(op_byte),
    .word_out(aligned_rd)
  );

  swap_wdata #(.DW(DW)) u_wdata (
    .value(op_data), .is_byte(op_byte), .bus_word(wr_word)
  );

  swap_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .inc(cnt_inc), .count(acc_cnt)
  );
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] cyc_total,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_byte,
  input logic          mem_lock,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  localparam int LANES = DW / 8;
  localparam logic [CW-1:0] MIN_CYC = CW'(3);

  logic rd_done;
  always_ff @(posedge clk) begin
    if (rst || done)                      rd_done <= 1'b0;
    else if (mem_req && mem_ack && !mem_we) rd_done <= 1'b1;
  end

  assert_lock_on_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock);

  assert_lock_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_lock) |-> $past(mem_req && mem_we && mem_ack));

  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> rd_done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_wack_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_req && mem_we && mem_ack));

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_byte_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_byte) |-> (mem_wdata == {LANES{mem_wdata[7:0]}}));

  assert_cyc_min_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_total >= MIN_CYC));

  assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

bind swap_seq swap_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cyc_total(cyc_total),
  .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_lock(mem_lock),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/swap_seq_tb.sv
`timescale 1ns/1ps
module swap_seq_tb;
  localparam int AW = 32, DW = 32, CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_byte = 1'b0;
  logic          busy, done, mem_req, mem_we, mem_byte, mem_lock;
  logic [DW-1:0] old_data, mem_wdata;
  logic [CW-1:0] cyc_total;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  swap_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .st_addr(st_addr), .st_data(st_data),
    .st_byte(st_byte), .busy(busy), .done(done), .old_data(old_data),
    .cyc_total(cyc_total), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;
  int wr_t = 0, ww_t = 0, wcnt = 0;
  int rd_issues, wr_issues, gap, rd_rise_cyc;
  bit lock_bad, stable_bad, order_bad, rd_acked, wr_started, cur_we, prev_req;
  logic [AW-1:0] rd_addr, wr_addr, prev_addr;
  logic          rd_byte, wr_byte;
  logic [DW-1:0] wr_data;

  function automatic logic [31:0] pat(input logic [31:0] a);
    logic [7:0] x;
    x = a[9:2];
    return {8'hA3 ^ x, 8'hB2 ^ x, 8'hC1 ^ x, 8'hD0 ^ x};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // Slave model and bus monitor in one process (negedge).
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
        if (!cur_we) rd_acked = 1'b1;
      end else if (mem_req) begin
        if (wcnt == (mem_we ? ww_t : wr_t)) begin
          mem_ack = 1'b1;
          if (!mem_we) mem_rdata = pat(mem_addr);
        end else wcnt++;
      end
      if (mem_req && !prev_req) begin
        cur_we = mem_we;
        if (!mem_we) begin
          rd_issues++; rd_addr = mem_addr; rd_byte = mem_byte; rd_rise_cyc = cyc;
        end else begin
          wr_issues++; wr_addr = mem_addr; wr_byte = mem_byte; wr_data = mem_wdata;
          wr_started = 1'b1;
          if (!rd_acked) order_bad = 1'b1;
        end
      end
      if (mem_req && prev_req && (mem_addr != prev_addr)) stable_bad = 1'b1;
      if (rd_acked && !wr_started && !mem_req) gap++;
      if ((mem_req || (rd_acked && !wr_started)) && !mem_lock) lock_bad = 1'b1;
      prev_req = mem_req;
      prev_addr = mem_addr;
    end
  end

  task automatic clear_stats();
    rd_issues = 0; wr_issues = 0; gap = 0; rd_rise_cyc = 0;
    lock_bad = 0; stable_bad = 0; order_bad = 0; rd_acked = 0; wr_started = 0;
  endtask

  task automatic do_swap(input logic [31:0] a, input logic [31:0] d, input bit b,
                         input int wr, input int ww, input bit inject);
    int c0, n;
    logic [63:0] dbl;
    logic [31:0] p, exp_old, exp_w;
    @(negedge clk);
    wr_t = wr; ww_t = ww;
    clear_stats();
    start = 1'b1; st_addr = a; st_data = d; st_byte = b;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      @(negedge clk);
      start = 1'b1; st_addr = a ^ 32'h0000_0F00; st_byte = ~b;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    p = pat(a);
    dbl = {p, p} >> (8 * a[1:0]);
    exp_old = b ? {24'h0, dbl[7:0]} : dbl[31:0];
    exp_w = b ? {4{d[7:0]}} : d;
    chk(done, "R9", "done seen", {31'h0, done}, 32'h1);
    chk(rd_rise_cyc - c0 == 2, "R2", "read issue latency", rd_rise_cyc - c0, 2);
    chk(rd_issues == 1 && rd_addr == a && rd_byte == b, b ? "R2_byte" : "R2",
        "read addr", rd_addr, a);
    chk(wr_issues == 1 && wr_addr == a && !order_bad, "R3", "write addr", wr_addr, a);
    chk(gap == 1, "R3", "gap cycles", gap, 1);
    chk(!lock_bad && !mem_lock, "R4", "lock window", {31'h0, lock_bad}, 0);
    chk(old_data == exp_old, b ? "R6" : "R5", "old data", old_data, exp_old);
    chk(wr_data == exp_w && wr_byte == b, "R7", "write data", wr_data, exp_w);
    chk(cyc_total == CW'(wr + ww + 3), "R8", "cycle total", cyc_total, wr + ww + 3);
    chk(!stable_bad, "R11", "addr stable", {31'h0, stable_bad}, 0);
    @(negedge clk);
    chk(!done && !busy, "R9", "done pulse end", {30'h0, done, busy}, 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(rd_issues == 1 && wr_issues == 1 && !mem_req && !busy, "R10",
          "start while busy ignored", rd_issues + wr_issues, 2);
    end
  endtask

  initial begin
    clear_stats();
    prev_req = 0; prev_addr = '0; cur_we = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !mem_lock, "R1", "in reset",
        {28'h0, busy, done, mem_req, mem_lock}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !mem_lock, "R1", "after reset",
        {28'h0, busy, done, mem_req, mem_lock}, 0);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 4; a++)
        for (int wr = 0; wr < 4; wr++)
          for (int ww = 0; ww < 4; ww++) begin
            int op;
            op = ((b * 4 + a) * 4 + wr) * 4 + ww;
            do_swap(32'h0000_4000 + (op << 4) + a,
                    {8'h9E, 8'h5A, 8'(op) ^ 8'h33, 8'(op)}, b[0], wr, ww, 1'b0);
          end
    do_swap(32'h0000_7002, 32'hCAFE_F00D, 1'b0, 3, 1, 1'b1);
    do_swap(32'h0000_7101, 32'h1234_56E7, 1'b1, 2, 2, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule